// File: doc/BRIEF.md
# Timed Pulse Period Meter

This block measures the average rate of a conditioned input over a window of a programmable number of clock cycles. Inside each window it looks for edges of the chosen polarity. The first such edge anchors a time counter that then runs on every clock. Each later edge records the current elapsed time and adds one to an edge tally. When the window closes, the block publishes two results: the time from the first counted edge to the last counted edge, and the number of edges after the first. It raises a one-cycle done strobe and opens the next window in the same clock.

Software divides the two results to get the frequency. The window length is read each time a window opens. Measurement starts when the block is enabled, either at once or after a start event. The start event can come from a software trigger, a hardware trigger or a rising gate input.

Top module: `tppm_meter`

## Requirements
- R1: While reset is high and in the first cycle after it, `res_hi`, `res_lo` and `done` are all zero.
- R2: Each window lasts `win_len` clocks. The value is sampled when the window opens, so a change made during a window only applies to the next one. Windows follow one another with no gap, and `done` pulses once per window, `win_len` cycles after the window opened.
- R3: A `win_len` value below 2 is treated as 2.
- R4: With `edge_fall` = 0, a selected edge is `sig_in` sampled low on one clock and high on the next. With `edge_fall` = 1, it is sampled high and then low. Edges of the other polarity have no effect on the results.
- R5: At window close, `res_hi` receives the number of clocks from the first selected edge of the window to its last selected edge. `res_lo` receives the number of selected edges after the first one.
- R6: A window with fewer than two selected edges reports zero in both `res_hi` and `res_lo`.
- R7: A selected edge that falls on the closing clock of a window counts as the first edge of the next window, not as the last edge of the closing one.
- R8: `done` is high for exactly one cycle, in the same cycle that the results change. Between strobes the results hold their values.
- R9: With `wait_trig` = 0, the first window opens on the clock where `en` is first seen high. With `wait_trig` = 1, the block waits until `trig_sw`, `trig_hw` or a rising `gate_in` is seen while enabled.
- R10: Driving `en` low stops measurement. No further `done` strobe occurs, and the results keep their last values. Enabling again starts a fresh window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Time-base clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Measurement enable |
| wait_trig | input | 1 | 1: hold off the first window until a start event |
| trig_sw | input | 1 | Software start pulse |
| trig_hw | input | 1 | Hardware start pulse |
| gate_in | input | 1 | Gate line; its rising edge is a start event |
| sig_in | input | 1 | Conditioned signal under measurement |
| edge_fall | input | 1 | 0: count rising edges, 1: count falling edges |
| win_len | input | 32 | Window length in clock cycles |
| res_hi | output | 32 | Clocks from first to last selected edge of the last window |
| res_lo | output | 32 | Selected edges after the first in the last window |
| done | output | 1 | One-cycle strobe when the results update |

## Verification
The delicate case is a selected edge that lands on the clock where a window closes. In that cycle, closing the window and detecting the first edge of the next window both happen. The bench places rising edges at window offsets 2, 5 and 8 with an eight-cycle window, plus one more edge at offset 12. It then expects (3, 1) for the first window and (4, 1) for the second. A design that counted the boundary edge in the first window would report (6, 2) and lose the anchor of the second window. The same clock also has a window close and a window-length change together, which is checked by rewriting `win_len` partway through a window.

// File: rtl/tppm_pkg.sv
package tppm_pkg;

    localparam int unsigned TPPM_W = 32;

    typedef enum logic {
        EDGE_RISE = 1'b0,
        EDGE_FALL = 1'b1
    } edge_sel_e;

    // running state of one measurement window
    typedef struct packed {
        logic              anchored;  // first selected edge seen
        logic [TPPM_W-1:0] elapsed;   // clocks since anchor edge
        logic [TPPM_W-1:0] last_at;   // elapsed value at latest later edge
        logic [TPPM_W-1:0] tally;     // selected edges after the anchor
    } meas_t;

    typedef struct packed {
        logic [TPPM_W-1:0] span;
        logic [TPPM_W-1:0] count;
    } result_t;

    function automatic logic [TPPM_W-1:0] floor_len(
        input logic [TPPM_W-1:0] req,
        input int unsigned       lowest
    );
        return (req < TPPM_W'(lowest)) ? TPPM_W'(lowest) : req;
    endfunction

endpackage

// File: rtl/tppm_edge.sv
module tppm_edge
    import tppm_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      sig_in,
    input  logic      gate_in,
    input  edge_sel_e pol,
    output logic      sig_hit,
    output logic      gate_rise
);
    logic sig_q;
    logic gate_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sig_q  <= 1'b0;
            gate_q <= 1'b0;
        end else begin
            sig_q  <= sig_in;
            gate_q <= gate_in;
        end
    end

    always_comb begin
        if (pol == EDGE_FALL) sig_hit = sig_q & ~sig_in;
        else                  sig_hit = ~sig_q & sig_in;
        gate_rise = gate_in & ~gate_q;
    end

endmodule

// File: rtl/tppm_window.sv
module tppm_window
    import tppm_pkg::*;
#(
    parameter int unsigned MIN_WIN = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              wait_trig,
    input  logic              trig_any,
    input  logic [TPPM_W-1:0] win_len,
    output logic              active,
    output logic              win_open,
    output logic              win_close
);
    logic              run_q;
    logic [TPPM_W-1:0] left_q;
    logic [TPPM_W-1:0] len_q;
    logic              start_now;
    logic [TPPM_W-1:0] len_eff;

    always_comb begin
        len_eff   = floor_len(win_len, MIN_WIN);
        start_now = en && !run_q && (!wait_trig || trig_any);
        win_close = en && run_q && (left_q == '0);
        win_open  = start_now || win_close;
        active    = en && (run_q || start_now);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q  <= 1'b0;
            left_q <= '0;
            len_q  <= TPPM_W'(MIN_WIN);
        end else if (!en) begin
            run_q  <= 1'b0;
        end else if (win_open) begin
            run_q  <= 1'b1;
            len_q  <= len_eff;
            left_q <= len_eff - 1'b1;
        end else if (run_q) begin
            left_q <= left_q - 1'b1;
        end
    end

    AST_LEN_FLOOR: assert property (@(posedge clk) disable iff (rst)
        run_q |-> (len_q >= TPPM_W'(MIN_WIN))); // R3
    AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (rst)
        run_q |-> (left_q < len_q)); // R2
    AST_STOP_ON_DISABLE: assert property (@(posedge clk) disable iff (rst)
        !en |=> !run_q); // R10
    AST_HOLD_FOR_START: assert property (@(posedge clk) disable iff (rst)
        (!run_q && wait_trig && !trig_any) |=> !run_q); // R9

endmodule

// File: rtl/tppm_accum.sv
module tppm_accum
    import tppm_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    active,
    input  logic    win_open,
    input  logic    win_close,
    input  logic    hit,
    output result_t result,
    output logic    done
);
    meas_t cur_q;
    meas_t base;

    // a window boundary clears the state before this clock's edge is applied
    always_comb begin
        base = win_open ? '0 : cur_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q  <= '0;
            result <= '0;
            done   <= 1'b0;
        end else begin
            done <= win_close;
            if (win_close) begin
                result.span  <= (cur_q.tally != '0) ? cur_q.last_at : '0;
                result.count <= cur_q.tally;
            end
            if (!active) begin
                cur_q <= '0;
            end else if (hit && !base.anchored) begin
                cur_q.anchored <= 1'b1;
                cur_q.elapsed  <= '0;
                cur_q.last_at  <= '0;
                cur_q.tally    <= '0;
            end else if (hit) begin
                cur_q.anchored <= 1'b1;
                cur_q.elapsed  <= base.elapsed + 1'b1;
                cur_q.last_at  <= base.elapsed + 1'b1;
                cur_q.tally    <= base.tally + 1'b1;
            end else begin
                cur_q.anchored <= base.anchored;
                cur_q.elapsed  <= base.anchored ? base.elapsed + 1'b1 : '0;
                cur_q.last_at  <= base.last_at;
                cur_q.tally    <= base.tally;
            end
        end
    end

    AST_RESULTS_HOLD: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(result)); // R8
    AST_SHORT_WINDOW_ZERO: assert property (@(posedge clk) disable iff (rst)
        (done && result.count == '0) |-> (result.span == '0)); // R6

endmodule

// File: rtl/tppm_meter.sv
module tppm_meter
    import tppm_pkg::*;
#(
    parameter int unsigned MIN_WIN = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              wait_trig,
    input  logic              trig_sw,
    input  logic              trig_hw,
    input  logic              gate_in,
    input  logic              sig_in,
    input  logic              edge_fall,
    input  logic [TPPM_W-1:0] win_len,
    output logic [TPPM_W-1:0] res_hi,
    output logic [TPPM_W-1:0] res_lo,
    output logic              done
);
    logic    sig_hit;
    logic    gate_rise;
    logic    active;
    logic    win_open;
    logic    win_close;
    result_t result;

    tppm_edge u_edge (
        .clk       (clk),
        .rst       (rst),
        .sig_in    (sig_in),
        .gate_in   (gate_in),
        .pol       (edge_sel_e'(edge_fall)),
        .sig_hit   (sig_hit),
        .gate_rise (gate_rise)
    );

    tppm_window #(.MIN_WIN(MIN_WIN)) u_window (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .wait_trig (wait_trig),
        .trig_any  (trig_sw | trig_hw | gate_rise),
        .win_len   (win_len),
        .active    (active),
        .win_open  (win_open),
        .win_close (win_close)
    );

    tppm_accum u_accum (
        .clk       (clk),
        .rst       (rst),
        .active    (active),
        .win_open  (win_open),
        .win_close (win_close),
        .hit       (sig_hit),
        .result    (result),
        .done      (done)
    );

    assign res_hi = result.span;
    assign res_lo = result.count;

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R8

endmodule

// File: tb/tb_tppm_meter.sv
module tb_tppm_meter;
    import tppm_pkg::*;

    localparam int W = TPPM_W;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic         rst = 1'b1;
    logic         en = 1'b0, wait_trig = 1'b0, trig_sw = 1'b0, trig_hw = 1'b0;
    logic         gate_in = 1'b0, sig_in = 1'b0, edge_fall = 1'b0;
    logic [W-1:0] win_len = 10;
    logic [W-1:0] res_hi, res_lo;
    logic         done;

    tppm_meter dut (
        .clk(clk), .rst(rst), .en(en), .wait_trig(wait_trig),
        .trig_sw(trig_sw), .trig_hw(trig_hw), .gate_in(gate_in),
        .sig_in(sig_in), .edge_fall(edge_fall), .win_len(win_len),
        .res_hi(res_hi), .res_lo(res_lo), .done(done)
    );

    int n_run = 0;
    int n_fail = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // reference model written from the requirements: edge positions in a window
    function automatic int unsigned floor2(input logic [W-1:0] v);
        return (v < 2) ? 2 : int'(v);
    endfunction

    logic         m_prev = 1'b0, m_gprev = 1'b0;
    bit           m_run = 0;
    int unsigned  m_pos, m_len, m_n, m_first, m_last;
    logic [W-1:0] e_hi = '0, e_lo = '0;
    bit           e_done = 0;

    always @(posedge clk) begin
        bit e, gr;
        if (rst) begin
            m_prev = 0; m_gprev = 0; m_run = 0;
            e_hi = '0; e_lo = '0; e_done = 0;
        end else begin
            e  = edge_fall ? (m_prev & !sig_in) : (!m_prev & sig_in);
            gr = gate_in & !m_gprev;
            e_done = 0;
            if (!en) m_run = 0;
            else if (!m_run) begin
                if (!wait_trig || trig_sw || trig_hw || gr) begin
                    m_run = 1; m_pos = 0; m_len = floor2(win_len); m_n = 0;
                end
            end else if (m_pos == m_len) begin
                e_done = 1;
                e_hi = (m_n >= 2) ? W'(m_last - m_first) : '0;
                e_lo = (m_n >= 2) ? W'(m_n - 1) : '0;
                m_pos = 0; m_len = floor2(win_len); m_n = 0;
            end
            if (m_run) begin
                if (e) begin
                    if (m_n == 0) m_first = m_pos;
                    m_last = m_pos;
                    m_n++;
                end
                m_pos++;
            end
            m_prev = sig_in; m_gprev = gate_in;
        end
    end

    bit chk_on = 0;
    always @(negedge clk) begin
        if (chk_on) begin
            chk(done === e_done, "R8 done strobe", done, e_done);
            chk(res_hi === e_hi, "R5 span result", res_hi, e_hi);
            chk(res_lo === e_lo, "R5 edge count", res_lo, e_lo);
        end
    end

    typedef struct packed {
        logic       fall;
        logic [15:0] len;
        logic [7:0]  half;
        logic [7:0]  ph;
        logic [7:0]  nwin;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{1'b0, 16'd20, 8'd3, 8'd0, 8'd4},
        '{1'b1, 16'd20, 8'd3, 8'd1, 8'd4},
        '{1'b0, 16'd37, 8'd5, 8'd2, 8'd3},
        '{1'b1, 16'd16, 8'd4, 8'd0, 8'd3},
        '{1'b0, 16'd50, 8'd1, 8'd0, 8'd2},
        '{1'b1, 16'd9,  8'd7, 8'd3, 8'd5}
    };

    task automatic idle(input int n);
        @(negedge clk);
        en = 0; sig_in = 0; wait_trig = 0; trig_sw = 0; trig_hw = 0; gate_in = 0;
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog R1 actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int cnt;
        // R1 reset state
        repeat (3) @(negedge clk);
        chk(res_hi == 0, "R1 res_hi in reset", res_hi, 0);
        chk(res_lo == 0, "R1 res_lo in reset", res_lo, 0);
        chk(done == 0, "R1 done in reset", done, 0);
        rst = 0;
        @(negedge clk);
        chk(res_hi == 0 && res_lo == 0 && done == 0, "R1 after reset", res_hi, 0);
        chk_on = 1;

        // R7 edge on the closing clock opens the next window
        edge_fall = 0; win_len = 8;
        for (int c = 0; c <= 17; c++) begin
            @(negedge clk);
            if (c == 9) begin
                chk(done == 1, "R7 first close", done, 1);
                chk(res_hi == 3, "R7 span w0", res_hi, 3);
                chk(res_lo == 1, "R7 count w0", res_lo, 1);
            end
            if (c == 17) begin
                chk(res_hi == 4, "R7 span w1", res_hi, 4);
                chk(res_lo == 1, "R7 count w1", res_lo, 1);
            end
            en = 1;
            sig_in = (c == 2 || c == 5 || c == 8 || c == 12);
        end
        // R10 disable: no strobe, results held
        @(negedge clk); en = 0; sig_in = 0;
        cnt = 0;
        for (int c = 0; c < 20; c++) begin
            @(negedge clk);
            sig_in = c[1];
            if (done) cnt++;
        end
        chk(cnt == 0, "R10 no strobe while disabled", cnt, 0);
        chk(res_hi == 4 && res_lo == 1, "R10 results held", res_hi, 4);
        idle(2);

        // R6 one edge, then none
        win_len = 10;
        for (int c = 0; c <= 21; c++) begin
            @(negedge clk);
            if (c == 11) chk(done == 1 && res_hi == 0 && res_lo == 0, "R6 single edge zero", res_hi, 0);
            if (c == 21) chk(done == 1 && res_lo == 0, "R6 empty window zero", res_lo, 0);
            en = 1; sig_in = (c == 3);
        end
        idle(3);

        // R4 falling edges only
        edge_fall = 1; win_len = 12;
        for (int c = 0; c <= 13; c++) begin
            @(negedge clk);
            if (c == 13) begin
                chk(res_hi == 7, "R4 falling span", res_hi, 7);
                chk(res_lo == 2, "R4 falling count", res_lo, 2);
            end
            en = 1; sig_in = (c <= 2) || (c == 5) || (c == 6) || (c == 9);
        end
        idle(3);
        edge_fall = 0;

        // R3 short length floored to 2
        win_len = 1; cnt = 0;
        for (int c = 0; c <= 20; c++) begin
            @(negedge clk);
            if (c >= 1 && done) cnt++;
            en = 1; sig_in = 0;
        end
        chk(cnt == 9, "R3 strobes with floor length", cnt, 9);
        idle(3);

        // R2 length sampled at window open
        win_len = 10;
        for (int c = 0; c <= 17; c++) begin
            @(negedge clk);
            if (c == 10) chk(done == 0, "R2 no early close", done, 0);
            if (c == 11) chk(done == 1, "R2 close after old length", done, 1);
            if (c == 16) chk(done == 1, "R2 close after new length", done, 1);
            en = 1; sig_in = (c % 4) < 2;
            if (c == 4) win_len = 5;
        end
        idle(3);

        // R9 start sources: software, hardware, gate
        for (int src = 0; src < 3; src++) begin
            win_len = 6; wait_trig = 1; cnt = 0;
            for (int c = 0; c <= 22; c++) begin
                @(negedge clk);
                if (c <= 16 && done) cnt++;
                if (c == 21) chk(done == 0, "R9 not before window", done, 0);
                if (c == 22) chk(done == 1, "R9 close after start", done, 1);
                en = 1; sig_in = c[0];
                trig_sw = (src == 0 && c == 15);
                trig_hw = (src == 1 && c == 15);
                gate_in = (src == 2 && c >= 15);
            end
            chk(cnt == 0, "R9 held off until start", cnt, 0);
            idle(3);
        end

        // R5 vector table of periodic inputs
        for (int v = 0; v < 6; v++) begin
            int len, half, ph, nw;
            len = int'(VECS[v].len); half = int'(VECS[v].half);
            ph = int'(VECS[v].ph); nw = int'(VECS[v].nwin);
            edge_fall = VECS[v].fall; win_len = W'(len); cnt = 0;
            for (int c = 0; c <= nw * len + 1; c++) begin
                @(negedge clk);
                if (c >= 1 && done) cnt++;
                en = 1; sig_in = (((c + ph) / half) % 2) == 1;
            end
            chk(cnt == nw, "R2 windows per vector", cnt, nw);
            idle(3);
        end

        chk_on = 0;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule